// File: doc/BRIEF.md
# Cache Line 36-Bit Word Unpacker

This block sits on the refill path between a second-level cache and a first-level data cache. A line from the second level is 16 words of 64 bits. When the machine runs in narrow-word mode, lines fetched from data memory are packed: only the lowest nine 64-bit slots hold data. Those nine slots form one 576-bit stream that carries sixteen 36-bit values. The block spreads that stream so each 64-bit first-level word holds one 36-bit value, zero-extended. Software can then treat memory as if the machine had a 36-bit word.

In all other cases the line is forwarded unchanged. This covers narrow-word mode switched off, and any line tagged as an instruction fetch. The refill logic presents a line with a one-cycle valid strobe, together with the mode bit and the region flag. The repacked or forwarded line appears one clock later with its own one-cycle valid strobe.

Top module: `word36_line_unpacker`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `out_valid` is 0 and `out_line` is all zeros.
- R2: `out_valid` is high in exactly the cycle that follows a cycle with `in_valid` high, and low in every other cycle.
- R3: When `narrow_en` is 0, the line captured with `in_valid` appears unchanged on `out_line` one cycle later.
- R4: When `is_data` is 0, the line is forwarded unchanged even if `narrow_en` is 1, because instruction lines are never repacked.
- R5: When `narrow_en` and `is_data` are both 1, output word k (bits [64k+63:64k]) carries packed bits [36k+35:36k] in its bits [35:0]. The packed stream is the concatenation of input slots 0 to 8, slot j sits at `in_line` bits [64j+63:64j], and packed bit 0 is bit 0 of slot 0.
- R6: In narrow-word mode, bits [63:36] of every output word are 0.
- R7: In narrow-word mode, input slots 9 to 15 have no effect on `out_line`.
- R8: In a cycle where `in_valid` was low, `out_line` keeps the value it held before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A second-level line is present this cycle |
| in_line | input | 1024 | Second-level line; slot j is bits [64j+63:64j] |
| narrow_en | input | 1 | Narrow-word (36-bit) machine mode enabled |
| is_data | input | 1 | 1 for a data fetch, 0 for an instruction fetch |
| out_valid | output | 1 | First-level line valid strobe |
| out_line | output | 1024 | First-level line; word k is bits [64k+63:64k] |

## Verification
Every result falls due exactly one rising edge after its stimulus, because there is a single output register stage. The bench therefore drives inputs on a falling edge and checks the line and strobe on the next falling edge. At that point the result is settled and the following input has not yet been captured. Back-to-back lines with the mode changing between them are checked one per cycle the same way. In idle cycles the bench checks that the strobe has dropped and that the line held its value.

// File: rtl/word36_line_unpacker_pkg.sv
package word36_line_unpacker_pkg;

    localparam int WORD_W       = 64;
    localparam int LINE_WORDS   = 16;
    localparam int NARROW_W     = 36;
    localparam int LINE_BITS    = WORD_W * LINE_WORDS;
    localparam int PACKED_BITS  = NARROW_W * LINE_WORDS;
    localparam int PACKED_SLOTS = (PACKED_BITS + WORD_W - 1) / WORD_W;
    localparam int PAD_W        = WORD_W - NARROW_W;

    typedef logic [LINE_BITS-1:0]   line_t;
    typedef logic [PACKED_BITS-1:0] packed_t;

    typedef enum logic [0:0] {
        XFER_PASS   = 1'b0,
        XFER_NARROW = 1'b1
    } xfer_mode_e;

    typedef struct packed {
        logic       valid;
        xfer_mode_e mode;
    } xfer_ctl_t;

    // True when every word of a line has zero bits above the narrow field.
    function automatic logic upper_clear(input line_t l);
        logic ok;
        ok = 1'b1;
        for (int k = 0; k < LINE_WORDS; k++) begin
            if (l[k*WORD_W + NARROW_W +: PAD_W] != '0) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/word36_mode_select.sv
module word36_mode_select
    import word36_line_unpacker_pkg::*;
(
    input  logic      in_valid,
    input  logic      narrow_en,
    input  logic      is_data,
    output xfer_ctl_t ctl
);
    always_comb begin
        ctl.valid = in_valid;
        ctl.mode  = (narrow_en && is_data) ? XFER_NARROW : XFER_PASS;
    end
endmodule

// File: rtl/word36_spreader.sv
module word36_spreader
    import word36_line_unpacker_pkg::*;
#(
    parameter int WORDS   = LINE_WORDS,
    parameter int SLOT_W  = WORD_W,
    parameter int FIELD_W = NARROW_W
) (
    input  logic [WORDS*SLOT_W-1:0] line_in,
    output logic [WORDS*SLOT_W-1:0] line_out
);
    localparam int STREAM_W = WORDS * FIELD_W;
    localparam int FILL_W   = SLOT_W - FIELD_W;

    logic [STREAM_W-1:0] stream;

    // Only the low slots feed the stream; the tail slots are never routed.
    assign stream = line_in[STREAM_W-1:0];

    for (genvar k = 0; k < WORDS; k++) begin : g_word
        assign line_out[k*SLOT_W +: SLOT_W] =
            {{FILL_W{1'b0}}, stream[k*FIELD_W +: FIELD_W]};
    end
endmodule

// File: rtl/word36_line_reg.sv
module word36_line_reg
    import word36_line_unpacker_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  line_t d,
    output logic  q_valid,
    output line_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q       <= '0;
        end else begin
            q_valid <= load;
            if (load) q <= d;
        end
    end

    p_strobe_follows_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> q_valid);
    p_strobe_drops_r2: assert property (@(posedge clk) disable iff (rst)
        !load |=> !q_valid);
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));
endmodule

// File: rtl/word36_line_unpacker.sv
module word36_line_unpacker
    import word36_line_unpacker_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [LINE_BITS-1:0] in_line,
    input  logic                 narrow_en,
    input  logic                 is_data,
    output logic                 out_valid,
    output logic [LINE_BITS-1:0] out_line
);
    xfer_ctl_t ctl;
    line_t     spread_line;
    line_t     next_line;

    word36_mode_select u_sel (
        .in_valid  (in_valid),
        .narrow_en (narrow_en),
        .is_data   (is_data),
        .ctl       (ctl)
    );

    word36_spreader #(
        .WORDS   (LINE_WORDS),
        .SLOT_W  (WORD_W),
        .FIELD_W (NARROW_W)
    ) u_spread (
        .line_in  (in_line),
        .line_out (spread_line)
    );

    always_comb begin
        unique case (ctl.mode)
            XFER_NARROW: next_line = spread_line;
            default:     next_line = in_line;
        endcase
    end

    word36_line_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .load    (ctl.valid),
        .d       (next_line),
        .q_valid (out_valid),
        .q       (out_line)
    );

    p_pass_mode_off_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !narrow_en) |=> (out_line == $past(in_line)));
    p_pass_instr_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !is_data) |=> (out_line == $past(in_line)));
    p_pad_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && narrow_en && is_data) |=> upper_clear(out_line));
    p_word0_field_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && narrow_en && is_data) |=>
        (out_line[NARROW_W-1:0] == $past(in_line[NARROW_W-1:0])));
endmodule

// File: tb/word36_line_unpacker_tb_top.sv
module word36_line_unpacker_tb_top;
    import word36_line_unpacker_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 in_valid;
    logic [LINE_BITS-1:0] in_line;
    logic                 narrow_en;
    logic                 is_data;
    logic                 out_valid;
    logic [LINE_BITS-1:0] out_line;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    word36_line_unpacker dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_line   (in_line),
        .narrow_en (narrow_en),
        .is_data   (is_data),
        .out_valid (out_valid),
        .out_line  (out_line)
    );

    function automatic line_t make_line(input logic [63:0] seed);
        line_t l;
        for (int j = 0; j < LINE_WORDS; j++) begin
            l[j*64 +: 64] = (64'h9E3779B97F4A7C15 * (64'(j) + 64'd1))
                            ^ (seed * 64'h0000_0100_0000_01B3) ^ {seed[31:0], seed[63:32]};
        end
        return l;
    endfunction

    // Expected narrow line built bit by bit from the packed-stream numbering.
    function automatic line_t expect_narrow(input line_t src);
        line_t e;
        e = '0;
        for (int k = 0; k < 16; k++)
            for (int b = 0; b < 36; b++)
                e[k*64 + b] = src[36*k + b];
        return e;
    endfunction

    task automatic chk_bit(input logic act, input logic exp_v, input string req);
        n_tests++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp_v);
        end
    endtask

    task automatic chk_line(input line_t act, input line_t exp_v, input string req);
        n_tests++;
        if (act !== exp_v) begin
            n_fail++;
            for (int k = 0; k < LINE_WORDS; k++) begin
                if (act[k*64 +: 64] !== exp_v[k*64 +: 64]) begin
                    $display("FAIL %s: word %0d actual %h expected %h", req, k,
                             act[k*64 +: 64], exp_v[k*64 +: 64]);
                    break;
                end
            end
        end
    endtask

    // Present one line at a falling edge, check it at the next falling edge.
    task automatic send_one(input line_t l, input logic ne, input logic dat,
                            input line_t exp_v, input string req);
        in_valid  = 1'b1;
        in_line   = l;
        narrow_en = ne;
        is_data   = dat;
        @(negedge clk);
        in_valid = 1'b0;
        chk_bit(out_valid, 1'b1, "R2");
        chk_line(out_line, exp_v, req);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; in_line = '0; narrow_en = 1'b0; is_data = 1'b0;
        repeat (3) @(negedge clk);
        chk_bit(out_valid, 1'b0, "R1");
        chk_line(out_line, '0, "R1");
        rst = 1'b0;
        @(negedge clk);
        chk_bit(out_valid, 1'b0, "R1");
        chk_line(out_line, '0, "R1");
    endtask

    task automatic t_mode_off();
        line_t l = make_line(64'd7);
        send_one(l, 1'b0, 1'b1, l, "R3");
        l = make_line(64'd123);
        send_one(l, 1'b0, 1'b0, l, "R3");
    endtask

    task automatic t_instr_region();
        line_t l = make_line(64'hABCD);
        send_one(l, 1'b1, 1'b0, l, "R4");
    endtask

    task automatic t_narrow_pattern();
        line_t l = make_line(64'h55);
        send_one(l, 1'b1, 1'b1, expect_narrow(l), "R5");
        l = make_line(64'hDEAD_BEEF);
        send_one(l, 1'b1, 1'b1, expect_narrow(l), "R5");
    endtask

    task automatic t_narrow_ones();
        line_t e;
        for (int k = 0; k < 16; k++) e[k*64 +: 64] = 64'h0000_000F_FFFF_FFFF;
        send_one('1, 1'b1, 1'b1, e, "R6");
    endtask

    task automatic t_walking_bit();
        // Packed bit 37 -> word 1 bit 1; it lives in slot 0 bit 37.
        line_t l = '0;
        line_t e = '0;
        l[37] = 1'b1;
        e[64 + 1] = 1'b1;
        send_one(l, 1'b1, 1'b1, e, "R5");
        // Top packed bit 575 -> word 15 bit 35; slot 8 bit 63.
        l = '0; e = '0;
        l[575] = 1'b1;
        e[15*64 + 35] = 1'b1;
        send_one(l, 1'b1, 1'b1, e, "R5");
    endtask

    task automatic t_tail_ignored();
        line_t a = make_line(64'h99);
        line_t b = a;
        line_t t = '0;
        b[LINE_BITS-1:576] = ~a[LINE_BITS-1:576];
        send_one(a, 1'b1, 1'b1, expect_narrow(a), "R7");
        send_one(b, 1'b1, 1'b1, expect_narrow(a), "R7");
        t[LINE_BITS-1:576] = '1;
        send_one(t, 1'b1, 1'b1, '0, "R7");
    endtask

    task automatic t_idle_hold();
        line_t l = make_line(64'h4242);
        send_one(l, 1'b1, 1'b1, expect_narrow(l), "R5");
        in_line = make_line(64'h1); narrow_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk_bit(out_valid, 1'b0, "R2");
            chk_line(out_line, expect_narrow(l), "R8");
        end
    endtask

    task automatic t_back_to_back();
        line_t l0 = make_line(64'h10);
        line_t l1 = make_line(64'h20);
        line_t l2 = make_line(64'h30);
        in_valid = 1'b1; in_line = l0; narrow_en = 1'b1; is_data = 1'b1;
        @(negedge clk);
        chk_bit(out_valid, 1'b1, "R2");
        chk_line(out_line, expect_narrow(l0), "R5");
        in_line = l1; narrow_en = 1'b0;
        @(negedge clk);
        chk_bit(out_valid, 1'b1, "R2");
        chk_line(out_line, l1, "R3");
        in_line = l2; narrow_en = 1'b1; is_data = 1'b0;
        @(negedge clk);
        chk_bit(out_valid, 1'b1, "R2");
        chk_line(out_line, l2, "R4");
        in_valid = 1'b0;
        @(negedge clk);
        chk_bit(out_valid, 1'b0, "R2");
        chk_line(out_line, l2, "R8");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_mode_off();
        t_instr_region();
        t_narrow_pattern();
        t_narrow_ones();
        t_walking_bit();
        t_tail_ignored();
        t_idle_hold();
        t_back_to_back();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule